// File: doc/BRIEF.md
# Packet Memory Command Unit

This block is the command engine of a packet buffer manager. A host writes a 4-bit operation code into a command register, along with a 3-bit page count and a packet number. The command takes effect in the cycle after the write strobe falls. The engine keeps a pool of 8 packet numbers that share 16 pages. It can grant a packet number with the number of pages asked for, and it can free a packet number again. It keeps two 8-entry queues of packet numbers. The first holds packets waiting for the transmit engine. The second holds packets that the transmit engine has finished with. It also clears these queues, or the whole pool, on request.

Freeing a packet takes a fixed four cycles, and a BUSY status bit covers that time. An allocation reports its outcome in a result byte and with a one-cycle interrupt pulse. Two reset commands exist. The queue reset empties both queues but keeps every allocation. The full reset returns all pages to the pool.

Top module: `pkt_cmd_unit`

## Requirements
- R1: A command is captured from `cmd_code`, `cmd_pages` and `pnr` in the last cycle that `cmd_wr` is high. It acts on the clock edge where `cmd_wr` is seen low after having been high. No output changes because of a command while the strobe is still high.
- R2: Code 4'h2 (allocate) needs `cmd_pages`+1 pages and picks the lowest-numbered free packet. It succeeds only if a packet is free and at least that many of the 16 pages are free. On success `alloc_res` becomes the packet number with bit 7 clear. On failure `alloc_res` becomes 8'h80 and nothing is allocated. In both cases `alloc_irq` is high for exactly the one cycle in which the new result appears.
- R3: `cmd_pages` is ignored by every code other than 4'h2. Codes other than 2, 4, 8, A, C and E change nothing.
- R4: Code 4'h8 removes the head of the completion queue and frees that packet's pages.
- R5: Code 4'hA frees the packet given in `pnr`.
- R6: `stat[0]` (BUSY) rises in the cycle a release is accepted and stays high for exactly 4 cycles. The packet's pages return to the pool on the edge where BUSY falls.
- R7: A release command is ignored if it arrives while BUSY is high. It is also ignored if its target packet is not allocated, or if it is code 4'h8 and the completion queue is empty. An ignored release sets `stat[1]`, which stays set until the full reset.
- R8: Code 4'hC pushes `pnr` onto the transmit queue, and `tx_take` pops the queue. `tx_head` shows the head with bit 3 clear, or 4'b1000 when the queue is empty. A push to a full queue (8 entries) is dropped.
- R9: `done_vld` pushes `done_pnum` onto the completion queue, and `cmpl_rd` pops it. `cmpl_head` shows the head, or 4'b1000 when the queue is empty. A push to a full queue is dropped.
- R10: Code 4'hE empties both queues. It frees no pages, keeps every allocation and lets a release in progress finish.
- R11: Code 4'h4 frees every packet and all 16 pages, empties both queues, ends any release, clears `stat[1]` and sets `alloc_res` to 0.
- R12: `stat[2]` is high when the transmit queue is empty and `stat[3]` is high when the completion queue is empty. After reset `stat` is 4'b1100 and `alloc_res` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_code | input | 4 | Operation code |
| cmd_pages | input | 3 | Page count minus one (allocate only) |
| pnr | input | 3 | Packet number operand |
| tx_take | input | 1 | Transmit engine pops the transmit queue |
| done_vld | input | 1 | Transmit engine pushes a finished packet |
| done_pnum | input | 3 | Finished packet number |
| cmpl_rd | input | 1 | Host pops the completion queue |
| stat | output | 4 | {cmpl empty, tx empty, release error, BUSY} |
| alloc_res | output | 8 | Allocation result: bit 7 failed, bits 2:0 packet |
| alloc_irq | output | 1 | One-cycle pulse when an allocation result appears |
| tx_head | output | 4 | Transmit queue head or empty marker |
| cmpl_head | output | 4 | Completion queue head or empty marker |

## Verification
Some page-accounting faults are silent at first. A page count that leaks, or a packet that is freed twice, does not show up until a later allocation fails or succeeds against the 16-page budget. The bench therefore ends its scenarios with allocations that land exactly on the limit. A fault in the release timer shows on BUSY within four cycles, and a queue pointer fault shows on the head ports at the next push or pop. The bench compares every output on every cycle with a behavioural model. Because of that, a stray change caused by an ignored command or an ignored page field is seen in the cycle it happens.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'h0,
    OP_ALLOC    = 4'h2,
    OP_WIPE     = 4'h4,
    OP_REL_DONE = 4'h8,
    OP_REL_NUM  = 4'hA,
    OP_ENQ      = 4'hC,
    OP_FLUSH    = 4'hE
  } op_e;

  // page field carries count minus one
  function automatic int unsigned pages_needed(input int unsigned field);
    return field + 1;
  endfunction

  // index of the lowest clear bit among the first n bits
  function automatic int unsigned lowest_clear(input logic [63:0] mask, input int unsigned n);
    int unsigned idx;
    idx = 0;
    for (int i = 63; i >= 0; i--) begin
      if (i < int'(n) && !mask[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/pmc_fifo.sv
module pmc_fifo #(
  parameter int W     = 3,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W:0]   head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;

  // internal events named for the checks
  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = empty ? {1'b1, {W{1'b0}}} : {1'b0, mem[rd_p]};

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!clr && do_push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wr_p <= bump(wr_p);
      if (do_pop)  rd_p <= bump(rd_p);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !clr |=> full && !empty);

  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);

endmodule

// File: rtl/pmc_pool.sv
module pmc_pool
  import pmc_pkg::*;
#(
  parameter int NPKT        = 8,
  parameter int TOTAL_PAGES = 16,
  parameter int REL_CYCLES  = 4,
  parameter int NB          = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wipe,
  input  logic                    alloc_req,
  input  logic [NB-1:0]           alloc_n,
  input  logic                    rel_go,
  input  logic [$clog2(NPKT)-1:0] rel_pnum,
  output logic                    alloc_ok,
  output logic [$clog2(NPKT)-1:0] alloc_pnum,
  output logic [NPKT-1:0]         held,
  output logic                    busy,
  output logic                    rel_fin
);
  localparam int NW = $clog2(NPKT);
  localparam int FW = $clog2(TOTAL_PAGES + 1);
  localparam int GW = NB + 1;
  localparam int TW = $clog2(REL_CYCLES + 1);

  logic [GW-1:0] pg [NPKT];
  logic [FW-1:0] free_pg;
  logic [TW-1:0] tcnt;
  logic [NW-1:0] tgt;
  logic [GW-1:0] need;
  logic          any_free;

  assign need       = GW'(pages_needed(int'(alloc_n)));
  assign any_free   = ~&held;
  assign alloc_pnum = NW'(lowest_clear(64'(held), NPKT));
  assign alloc_ok   = alloc_req && any_free && (int'(need) <= int'(free_pg));
  assign rel_fin    = busy && (tcnt == '0);

  always_ff @(posedge clk) begin
    if (alloc_ok && !wipe) pg[alloc_pnum] <= need;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      held    <= '0;
      free_pg <= FW'(TOTAL_PAGES);
      busy    <= 1'b0;
      tcnt    <= '0;
      tgt     <= '0;
    end else begin
      free_pg <= free_pg + (rel_fin ? FW'(pg[tgt]) : '0) - (alloc_ok ? FW'(need) : '0);
      held    <= (held & ~(rel_fin ? (NPKT'(1) << tgt) : '0))
               | (alloc_ok ? (NPKT'(1) << alloc_pnum) : '0);
      if (rel_go) begin
        busy <= 1'b1;
        tcnt <= TW'(REL_CYCLES - 1);
        tgt  <= rel_pnum;
      end else if (busy) begin
        if (tcnt == '0) busy <= 1'b0;
        else            tcnt <= tcnt - TW'(1);
      end
    end
  end

  int held_sum;
  always_comb begin
    held_sum = 0;
    for (int i = 0; i < NPKT; i++) if (held[i]) held_sum += int'(pg[i]);
  end

  // R11
  pool_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_pg) + held_sum == TOTAL_PAGES);

  // R6
  release_holds_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_go |=> busy);

  // R7
  no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rel_go);

  // R5
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_fin |=> !held[$past(tgt)]);

endmodule

// File: rtl/pkt_cmd_unit.sv
module pkt_cmd_unit
  import pmc_pkg::*;
#(
  parameter int NPKT        = 8,
  parameter int TOTAL_PAGES = 16,
  parameter int REL_CYCLES  = 4,
  parameter int QDEPTH      = 8,
  parameter int NB          = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_wr,
  input  logic [3:0]              cmd_code,
  input  logic [NB-1:0]           cmd_pages,
  input  logic [$clog2(NPKT)-1:0] pnr,
  input  logic                    tx_take,
  input  logic                    done_vld,
  input  logic [$clog2(NPKT)-1:0] done_pnum,
  input  logic                    cmpl_rd,
  output logic [3:0]              stat,
  output logic [7:0]              alloc_res,
  output logic                    alloc_irq,
  output logic [$clog2(NPKT):0]   tx_head,
  output logic [$clog2(NPKT):0]   cmpl_head
);
  localparam int NW = $clog2(NPKT);

  logic          wr_q;
  logic [3:0]    op_q;
  logic [NB-1:0] n_q;
  logic [NW-1:0] pn_q;

  // R1: latch while strobe high, act on its fall
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      op_q <= '0;
      n_q  <= '0;
      pn_q <= '0;
    end else begin
      wr_q <= cmd_wr;
      if (cmd_wr) begin
        op_q <= cmd_code;
        n_q  <= cmd_pages;
        pn_q <= pnr;
      end
    end
  end

  logic trail;
  assign trail = wr_q && !cmd_wr;

  logic is_alloc, is_wipe, is_rel_done, is_rel_num, is_enq, is_flush;
  assign is_alloc    = trail && (op_q == OP_ALLOC);
  assign is_wipe     = trail && (op_q == OP_WIPE);
  assign is_rel_done = trail && (op_q == OP_REL_DONE);
  assign is_rel_num  = trail && (op_q == OP_REL_NUM);
  assign is_enq      = trail && (op_q == OP_ENQ);
  assign is_flush    = trail && (op_q == OP_FLUSH);

  logic          tx_empty, tx_full, cmpl_empty, cmpl_full;
  logic          alloc_ok, busy, rel_fin;
  logic [NW-1:0] alloc_pnum;
  logic [NPKT-1:0] held;

  logic          rel_any, tgt_ok, rel_go, rel_bad, q_clr, cmpl_pop;
  logic [NW-1:0] rel_tgt;
  assign rel_any  = is_rel_done || is_rel_num;
  assign rel_tgt  = is_rel_done ? cmpl_head[NW-1:0] : pn_q;
  assign tgt_ok   = is_rel_done ? (!cmpl_empty && held[rel_tgt]) : held[rel_tgt];
  assign rel_go   = rel_any && !busy && tgt_ok;
  assign rel_bad  = rel_any && !rel_go;
  assign q_clr    = is_wipe || is_flush;
  assign cmpl_pop = cmpl_rd || (rel_go && is_rel_done);

  pmc_pool #(
    .NPKT(NPKT), .TOTAL_PAGES(TOTAL_PAGES), .REL_CYCLES(REL_CYCLES), .NB(NB)
  ) u_pool (
    .clk(clk), .rst_n(rst_n), .wipe(is_wipe),
    .alloc_req(is_alloc), .alloc_n(n_q),
    .rel_go(rel_go), .rel_pnum(rel_tgt),
    .alloc_ok(alloc_ok), .alloc_pnum(alloc_pnum), .held(held),
    .busy(busy), .rel_fin(rel_fin)
  );

  pmc_fifo #(.W(NW), .DEPTH(QDEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(q_clr),
    .push(is_enq), .din(pn_q), .pop(tx_take),
    .head(tx_head), .empty(tx_empty), .full(tx_full)
  );

  pmc_fifo #(.W(NW), .DEPTH(QDEPTH)) u_cmplq (
    .clk(clk), .rst_n(rst_n), .clr(q_clr),
    .push(done_vld), .din(done_pnum), .pop(cmpl_pop),
    .head(cmpl_head), .empty(cmpl_empty), .full(cmpl_full)
  );

  logic err;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err       <= 1'b0;
      alloc_res <= 8'h00;
      alloc_irq <= 1'b0;
    end else begin
      alloc_irq <= is_alloc;
      if (is_wipe) begin
        err       <= 1'b0;
        alloc_res <= 8'h00;
      end else begin
        if (rel_bad) err <= 1'b1;
        if (is_alloc) alloc_res <= alloc_ok ? 8'(alloc_pnum) : 8'h80;
      end
    end
  end

  assign stat = {cmpl_empty, tx_empty, err, busy};

  // R2
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_irq |=> !alloc_irq);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !is_wipe |=> err);

  // R1
  busy_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trail));

  // R9
  cmpl_full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_full |-> !cmpl_empty);

endmodule

// File: tb/pkt_cmd_unit_test.sv
module pkt_cmd_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [3:0] cmd_code = '0;
  logic [2:0] cmd_pages = '0;
  logic [2:0] pnr = '0;
  logic       tx_take = 1'b0;
  logic       done_vld = 1'b0;
  logic [2:0] done_pnum = '0;
  logic       cmpl_rd = 1'b0;
  logic [3:0] stat;
  logic [7:0] alloc_res;
  logic       alloc_irq;
  logic [3:0] tx_head, cmpl_head;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_cmd_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .cmd_pages(cmd_pages), .pnr(pnr), .tx_take(tx_take), .done_vld(done_vld),
    .done_pnum(done_pnum), .cmpl_rd(cmpl_rd), .stat(stat), .alloc_res(alloc_res),
    .alloc_irq(alloc_irq), .tx_head(tx_head), .cmpl_head(cmpl_head)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_wr_q;
  int m_op, m_n, m_pn;
  bit m_held[8];
  int m_pg[8];
  int m_free;
  bit m_busy;
  int m_cnt, m_tgt;
  bit m_err, m_irq;
  int m_res;
  int txq[$];
  int cq[$];

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_wr_q = 0; m_op = 0; m_n = 0; m_pn = 0;
    foreach (m_held[i]) begin m_held[i] = 0; m_pg[i] = 0; end
    m_free = 16; m_busy = 0; m_cnt = 0; m_tgt = 0;
    m_err = 0; m_irq = 0; m_res = 0;
    txq.delete(); cq.delete();
  endtask

  task automatic model_step();
    bit trail, fin, go, ok;
    int op, need, pick, tgt, tsz, csz;
    trail = m_wr_q && !cmd_wr;
    op = trail ? m_op : -1;
    if (op == 4) begin
      foreach (m_held[i]) m_held[i] = 0;
      m_free = 16; m_busy = 0; m_err = 0; m_res = 0; m_irq = 0;
      txq.delete(); cq.delete();
    end else begin
      fin = m_busy && (m_cnt == 0);
      ok = 0; pick = -1; need = m_n + 1;
      if (op == 2) begin
        for (int i = 7; i >= 0; i--) if (!m_held[i]) pick = i;
        ok = (pick >= 0) && (m_free >= need);
      end
      go = 0; tgt = 0;
      if (op == 8 || op == 10) begin
        if (op == 8) begin
          if (cq.size() > 0) begin tgt = cq[0]; go = !m_busy && m_held[tgt]; end
        end else begin
          tgt = m_pn; go = !m_busy && m_held[tgt];
        end
        if (!go) m_err = 1;
      end
      if (fin) begin m_held[m_tgt] = 0; m_free += m_pg[m_tgt]; end
      m_irq = (op == 2);
      if (op == 2) begin
        if (ok) begin m_held[pick] = 1; m_pg[pick] = need; m_free -= need; m_res = pick; end
        else m_res = 128;
      end
      if (m_busy) begin
        if (m_cnt == 0) m_busy = 0; else m_cnt--;
      end
      if (go) begin m_busy = 1; m_cnt = 3; m_tgt = tgt; end
      if (op == 14) begin
        txq.delete(); cq.delete();
      end else begin
        tsz = txq.size(); csz = cq.size();
        if (tx_take && tsz > 0) void'(txq.pop_front());
        if (op == 12 && tsz < 8) txq.push_back(m_pn);
        if ((cmpl_rd || (go && op == 8)) && csz > 0) void'(cq.pop_front());
        if (done_vld && csz < 8) cq.push_back(int'(done_pnum));
      end
    end
    m_wr_q = cmd_wr;
    if (cmd_wr) begin m_op = cmd_code; m_n = cmd_pages; m_pn = pnr; end
  endtask

  task automatic compare();
    chk(stat[0], m_busy, "R6 busy vs model");
    chk(stat[1], m_err, "R7 error bit vs model");
    chk(stat[2], txq.size() == 0, "R12 tx empty vs model");
    chk(stat[3], cq.size() == 0, "R12 cmpl empty vs model");
    chk(alloc_res, m_res, "R2 result vs model");
    chk(alloc_irq, m_irq, "R2 irq vs model");
    chk(tx_head, txq.size() > 0 ? txq[0] : 8, "R8 tx head vs model");
    chk(cmpl_head, cq.size() > 0 ? cq[0] : 8, "R9 cmpl head vs model");
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) model_reset(); else model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic cmd(input int op, input int n, input int pn);
    cmd_wr = 1; cmd_code = 4'(op); cmd_pages = 3'(n); pnr = 3'(pn);
    tick();
    cmd_wr = 0;
    tick();
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp_tx[8] = '{2, 3, 4, 5, 6, 7, 0, 8};
    model_reset();
    @(negedge clk);
    idle(3);
    rst_n = 1;
    tick();
    chk(stat, 4'b1100, "R12 reset status");
    chk(alloc_res, 0, "R12 reset result");

    // R1: nothing while strobe high
    cmd_wr = 1; cmd_code = 4'h2; cmd_pages = 3'd1; pnr = 0;
    tick();
    chk(alloc_irq, 0, "R1 no irq while strobe high");
    cmd_wr = 0;
    tick();
    chk(alloc_irq, 1, "R1 acts after strobe falls");
    chk(alloc_res, 0, "R2 first alloc packet 0");
    cmd(2, 7, 0);
    chk(alloc_res, 1, "R2 eight pages packet 1");
    cmd(2, 6, 0);
    chk(alloc_res, 8'h80, "R2 too few pages fails");
    tick();
    chk(alloc_irq, 0, "R2 irq one cycle");
    cmd(2, 5, 0);
    chk(alloc_res, 2, "R2 exact fit packet 2");

    // R3
    cmd(6, 7, 3);
    chk(alloc_res, 2, "R3 unused code keeps result");
    chk(stat, 4'b1100, "R3 unused code keeps status");
    cmd(12, 7, 1);
    chk(tx_head, 1, "R3 page field ignored by enqueue");

    // R8
    for (int p = 2; p < 8; p++) cmd(12, 0, p);
    cmd(12, 0, 0);
    cmd(12, 0, 5);
    chk(tx_head, 1, "R8 head after full");
    tx_take = 1;
    for (int i = 0; i < 8; i++) begin
      tick();
      chk(tx_head, exp_tx[i], "R8 pop order and drop on full");
    end
    tx_take = 0;

    // R9
    done_vld = 1; done_pnum = 2; tick();
    done_pnum = 0; tick();
    done_vld = 0;
    chk(cmpl_head, 2, "R9 completion head");
    chk(stat[3], 0, "R12 cmpl not empty");

    // R4 and R6
    cmd(8, 7, 0);
    chk(stat[0], 1, "R6 busy rises");
    chk(cmpl_head, 0, "R4 head removed");
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(stat[0], 1, "R6 busy held");
    end
    tick();
    chk(stat[0], 0, "R6 busy falls after 4");
    cmd(2, 5, 0);
    chk(alloc_res, 2, "R4 pages of packet 2 returned");

    // R5 and R7
    cmd(10, 0, 1);
    cmd(10, 0, 0);
    chk(stat[1], 1, "R7 release while busy flagged");
    idle(4);
    chk(stat[0], 0, "R6 busy done");
    chk(stat[1], 1, "R7 error sticky");
    cmd(2, 7, 0);
    chk(alloc_res, 1, "R5 packet 1 freed");
    cmd(2, 0, 0);
    chk(alloc_res, 8'h80, "R7 ignored release kept packet 0");

    // R10
    cmd(12, 0, 3);
    cmd(14, 0, 0);
    chk(tx_head, 8, "R10 tx queue emptied");
    chk(cmpl_head, 8, "R10 cmpl queue emptied");
    chk(stat[3:2], 2'b11, "R10 empty flags");
    cmd(2, 0, 0);
    chk(alloc_res, 8'h80, "R10 no pages freed");
    cmd(10, 0, 0);
    cmd(14, 0, 0);
    chk(stat[0], 1, "R10 release continues");
    idle(4);
    cmd(2, 1, 0);
    chk(alloc_res, 0, "R10 release completed across flush");

    // R11
    cmd(4, 0, 0);
    chk(stat, 4'b1100, "R11 status cleared");
    chk(alloc_res, 0, "R11 result cleared");
    cmd(10, 0, 5);
    chk(stat[1], 1, "R7 unallocated release flagged");
    chk(stat[0], 0, "R7 unallocated release not busy");
    cmd(4, 0, 0);
    chk(stat[1], 0, "R11 error cleared");
    cmd(2, 7, 0);
    chk(alloc_res, 0, "R11 pool refilled a");
    cmd(2, 7, 0);
    chk(alloc_res, 1, "R11 pool refilled b");
    cmd(2, 0, 0);
    chk(alloc_res, 8'h80, "R11 sixteen pages used");
    cmd(10, 0, 0);
    cmd(4, 0, 0);
    chk(stat[0], 0, "R11 ends release");
    idle(6);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule